// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several localities currently owns a shared register interface of a security coprocessor. Each locality sees its own 4 KB window. The locality number is taken from address bits [14:12], and the ownership control register sits at offset 0 of each window. Software in a locality writes that register to ask for ownership, to give it up, or to take it by force from a lower locality. Reading the same register shows whether the locality owns the interface, whether it was forced out, whether it has a request outstanding, and whether any other locality is waiting.

The block reports the owning locality on `active_loc`. The value 0xFF means no owner. A one-cycle `loc_changed` pulse goes out whenever a new owner is installed. When ownership has to move away from an owner whose command engine is busy, the block raises `abort_req`. It then holds the switch until the engine answers with `abort_ack`. Writes that land in the highest locality's window come from a path software cannot use, and they never change state.

Top module: `loc_arbiter`

## Requirements
- R1: After a synchronous reset, `active_loc` is 0xFF, `abort_req` and `loc_changed` are 0, and no request, seize or seized flag is set.
- R2: A read of offset 0 of a locality returns bit7=1, bit6=0, bit5=owner, bit4=seized, bit3=0, bit2=pending, bit1=request, bit0=inverse of `estab_in`. The value appears on `rdata` the cycle after `rd_en`. Any other offset, or a locality number of 5 or more, reads 0xFF.
- R3: Writing bit1 (request) while nobody owns the interface makes the writer the owner. `loc_changed` is high for exactly the cycle in which `active_loc` first shows the new owner.
- R4: Writing bit1 while another locality owns the interface only sets the writer's request flag. Every other locality then reads bit2 (pending) as 1, while the writer itself does not.
- R5: When the owner writes bit5=1, ownership passes to the highest-numbered locality with its request flag set. If no locality has a request, `active_loc` becomes 0xFF and `loc_changed` stays low.
- R6: When a non-owner writes bit5=1, only that locality's own request flag is cleared.
- R7: A write of bit3 (seize) is accepted only if nobody owns the interface or the writer's number is above the owner's. An accepted seize makes the writer the owner, and every other seize is ignored.
- R8: After an accepted seize, the former owner reads bit4 (seized)=1 and bit5=0. Writing bit4=1 clears its seized flag.
- R9: Any write into the window of locality NUM_LOC-1 (locality 4) has no effect.
- R10: If `cmd_busy` is high when a hand-off to another locality is decided, `abort_req` rises the next cycle and `active_loc` holds. The switch is seen the cycle after `abort_ack` is sampled, and `abort_req` falls in that same cycle. Access writes are ignored while `abort_req` is high.
- R11: A written value with bit3 set has bits 5 and 1 masked off, so only the seize is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 15 | Byte address; [14:12] locality, [11:0] offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| estab_in | input | 1 | Establishment flag; read back inverted in bit0 |
| cmd_busy | input | 1 | Command engine busy for the current owner |
| abort_req | output | 1 | Request to the command engine to abort before a hand-off |
| abort_ack | input | 1 | Abort finished |
| active_loc | output | 8 | Owning locality, 0xFF when none |
| loc_changed | output | 1 | One-cycle pulse when a new owner is installed |

## Verification
The bench builds the block with its defaults: five localities, a 12-bit window offset and a 15-bit address. With four writable localities, every owner can be paired with every one of the sixteen request sets before a release. Every owner/seizer pair can also be tried, so the whole priority and seize-acceptance space is swept rather than sampled. Directed sequences with `cmd_busy` held high cover the abort wait, writes arriving during that wait, and the read layout under both levels of `estab_in`.

// File: rtl/loc_arb_pkg.sv
`timescale 1ns/1ps
package loc_arb_pkg;
  localparam logic [7:0] LOC_NONE = 8'hFF;
  // bit positions in the per-locality ownership register
  localparam int B_REGOK  = 7;
  localparam int B_OWNER  = 5;
  localparam int B_SEIZED = 4;
  localparam int B_SEIZE  = 3;
  localparam int B_PEND   = 2;
  localparam int B_REQ    = 1;
  localparam int B_EST    = 0;
endpackage

// File: rtl/loc_arb_prio.sv
`timescale 1ns/1ps
// Finds the highest-numbered set bit of a request vector.
module loc_arb_prio #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/loc_arb_rdmux.sv
`timescale 1ns/1ps
// Registered readback of the ownership register of one locality.
module loc_arb_rdmux
  import loc_arb_pkg::*;
#(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          rd_hit,
  input  logic [IW-1:0] rd_loc,
  input  logic          is_owner,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  seized,
  input  logic          estab_in,
  output logic [7:0]    rdata
);
  logic [N-1:0] others;
  logic [7:0]   word;

  always_comb begin
    for (int i = 0; i < N; i++) others[i] = (IW'(i) != rd_loc) && req[i];
    word           = 8'h00;
    word[B_REGOK]  = 1'b1;
    word[B_OWNER]  = is_owner;
    word[B_SEIZED] = seized[rd_loc];
    word[B_PEND]   = |others;
    word[B_REQ]    = req[rd_loc];
    word[B_EST]    = ~estab_in;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= rd_hit ? word : 8'hFF;
  end
endmodule

// File: rtl/loc_arbiter.sv
`timescale 1ns/1ps
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC   = 5,
  parameter int LOC_SHIFT = 12,
  parameter int ADDR_W    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              estab_in,
  input  logic              cmd_busy,
  output logic              abort_req,
  input  logic              abort_ack,
  output logic [7:0]        active_loc,
  output logic              loc_changed
);
  localparam int IDX_W   = $clog2(NUM_LOC);
  localparam int FIELD_W = ADDR_W - LOC_SHIFT;
  localparam int HW_LOC  = NUM_LOC - 1;

  logic [NUM_LOC-1:0] req_q, seize_q, seized_q;
  logic [NUM_LOC-1:0] req_d, seize_d, seized_d;
  logic [7:0]         active_q, act_d, next_q, nxt_d, tgt;
  logic               pend_q, pend_d, chg_q, chg_d, go;
  logic [NUM_LOC-1:0] hi_mask, lo_mask;
  logic [7:0]         v;

  // address decode
  logic [FIELD_W-1:0] acc_loc;
  logic               in_win, loc_ok, wr_acc, act_valid, owner, rd_owner;
  logic [IDX_W-1:0]   wloc, a_idx;
  assign acc_loc   = addr[ADDR_W-1:LOC_SHIFT];
  assign in_win    = (addr[LOC_SHIFT-1:0] == '0);
  assign loc_ok    = (acc_loc < FIELD_W'(NUM_LOC));
  assign wloc      = acc_loc[IDX_W-1:0];
  assign wr_acc    = wr_en && in_win && loc_ok && (acc_loc != FIELD_W'(HW_LOC));
  assign act_valid = (active_q != LOC_NONE);
  assign a_idx     = active_q[IDX_W-1:0];
  assign owner     = act_valid && (a_idx == wloc);
  assign rd_owner  = owner;

  always_comb begin
    for (int i = 0; i < NUM_LOC; i++) begin
      hi_mask[i] = (IDX_W'(i) > wloc);
      lo_mask[i] = (IDX_W'(i) < wloc);
    end
  end

  logic             rq_hit;
  logic [IDX_W-1:0] rq_idx;
  loc_arb_prio #(.N(NUM_LOC), .IW(IDX_W)) u_prio (
    .req(req_q), .hit(rq_hit), .idx(rq_idx)
  );

  always_comb begin
    req_d    = req_q;
    seize_d  = seize_q;
    seized_d = seized_q;
    act_d    = active_q;
    pend_d   = pend_q;
    nxt_d    = next_q;
    chg_d    = 1'b0;
    go       = 1'b0;
    tgt      = LOC_NONE;
    v        = wdata;
    if (v[B_SEIZE]) begin
      v[B_REQ]   = 1'b0;
      v[B_OWNER] = 1'b0;
    end
    if (pend_q) begin
      if (abort_ack) begin
        go     = 1'b1;
        tgt    = next_q;
        pend_d = 1'b0;
      end
    end else if (wr_acc) begin
      if (v[B_SEIZED]) seized_d[wloc] = 1'b0;
      if (v[B_OWNER]) begin
        if (owner) begin
          if (rq_hit && cmd_busy) begin
            pend_d = 1'b1;
            nxt_d  = 8'(rq_idx);
          end else begin
            go  = 1'b1;
            tgt = rq_hit ? 8'(rq_idx) : LOC_NONE;
          end
        end else begin
          req_d[wloc] = 1'b0;
        end
      end else if (v[B_SEIZE]) begin
        if ((!act_valid || wloc > a_idx) && !seize_q[wloc] &&
            ((seize_q & hi_mask) == '0)) begin
          seize_d       = seize_d & ~lo_mask;
          seize_d[wloc] = 1'b1;
          if (act_valid && cmd_busy) begin
            pend_d = 1'b1;
            nxt_d  = 8'(wloc);
          end else begin
            go  = 1'b1;
            tgt = 8'(wloc);
          end
        end
      end else if (v[B_REQ] && !owner) begin
        if (act_valid) req_d[wloc] = 1'b1;
        else begin
          go  = 1'b1;
          tgt = 8'(wloc);
        end
      end
    end
    // ownership switch
    if (go && tgt != active_q) begin
      if (act_valid) begin
        if (tgt != LOC_NONE && seize_d[tgt[IDX_W-1:0]]) seized_d[a_idx] = 1'b1;
        else                                            req_d[a_idx]    = 1'b0;
      end
      act_d = tgt;
      if (tgt != LOC_NONE) begin
        req_d[tgt[IDX_W-1:0]]   = 1'b0;
        seize_d[tgt[IDX_W-1:0]] = 1'b0;
        chg_d                   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      seize_q  <= '0;
      seized_q <= '0;
      active_q <= LOC_NONE;
      next_q   <= LOC_NONE;
      pend_q   <= 1'b0;
      chg_q    <= 1'b0;
    end else begin
      req_q    <= req_d;
      seize_q  <= seize_d;
      seized_q <= seized_d;
      active_q <= act_d;
      next_q   <= nxt_d;
      pend_q   <= pend_d;
      chg_q    <= chg_d;
    end
  end

  loc_arb_rdmux #(.N(NUM_LOC), .IW(IDX_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_hit(in_win && loc_ok),
    .rd_loc(wloc), .is_owner(rd_owner), .req(req_q), .seized(seized_q),
    .estab_in(estab_in), .rdata(rdata)
  );

  assign active_loc  = active_q;
  assign abort_req   = pend_q;
  assign loc_changed = chg_q;
endmodule

// File: rtl/loc_arbiter_chk.sv
`timescale 1ns/1ps
module loc_arbiter_chk #(
  parameter int NUM_LOC   = 5,
  parameter int LOC_SHIFT = 12,
  parameter int ADDR_W    = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              abort_req,
  input logic              abort_ack,
  input logic [7:0]        active_loc,
  input logic              loc_changed
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (active_loc == 8'hFF) && !abort_req && !loc_changed);
  // R3
  a_r3_pulse_valid_owner: assert property (@(posedge clk) disable iff (rst)
    loc_changed |-> (active_loc < 8'(NUM_LOC)));
  a_r3_pulse_on_move: assert property (@(posedge clk) disable iff (rst)
    loc_changed |-> (active_loc != $past(active_loc)));
  // R9
  a_r9_hw_window_inert: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !abort_req &&
     addr[ADDR_W-1:LOC_SHIFT] == (ADDR_W-LOC_SHIFT)'(NUM_LOC-1)) |=> $stable(active_loc));
  // R10
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !abort_ack) |=> abort_req && $stable(active_loc));
  a_r10_ack_switches: assert property (@(posedge clk) disable iff (rst)
    (abort_req && abort_ack) |=> !abort_req && loc_changed);
endmodule

bind loc_arbiter loc_arbiter_chk #(
  .NUM_LOC(NUM_LOC), .LOC_SHIFT(LOC_SHIFT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .abort_req(abort_req),
  .abort_ack(abort_ack), .active_loc(active_loc), .loc_changed(loc_changed)
);

// File: tb/loc_arbiter_test.sv
`timescale 1ns/1ps
module loc_arbiter_test;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0, rdata, active_loc;
  logic        estab_in = 1'b0, cmd_busy = 1'b0, abort_ack = 1'b0;
  logic        abort_req, loc_changed;
  int          n_chk = 0, n_bad = 0;
  logic [7:0]  rv;

  always #2.5 clk = ~clk;

  loc_arbiter uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .estab_in(estab_in), .cmd_busy(cmd_busy),
    .abort_req(abort_req), .abort_ack(abort_ack), .active_loc(active_loc),
    .loc_changed(loc_changed)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int l, input logic [7:0] val);
    wr_en = 1'b1; addr = 15'(l << 12); wdata = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int l, input int off, output logic [7:0] val);
    rd_en = 1'b1; addr = 15'((l << 12) + off);
    @(negedge clk);
    rd_en = 1'b0;
    val = rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=00 exp=01");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 / R2 reset state and read layout
    chk("R1 active", active_loc, 8'hFF);
    chk("R1 abort", {7'd0, abort_req}, 8'h00);
    chk("R1 changed", {7'd0, loc_changed}, 8'h00);
    rd(0, 0, rv); chk("R2 est0 read", rv, 8'h81);
    estab_in = 1'b1;
    rd(1, 0, rv); chk("R2 est1 read", rv, 8'h80);
    rd(1, 4, rv); chk("R2 other offset", rv, 8'hFF);
    rd(5, 0, rv); chk("R2 loc5", rv, 8'hFF);
    rd(7, 0, rv); chk("R2 loc7", rv, 8'hFF);
    // R3 grant when idle
    wr(1, 8'h02);
    chk("R3 owner", active_loc, 8'd1);
    chk("R3 pulse", {7'd0, loc_changed}, 8'h01);
    @(negedge clk);
    chk("R3 pulse one cycle", {7'd0, loc_changed}, 8'h00);
    rd(1, 0, rv); chk("R3 owner read", rv, 8'hA0);
    // R4 request while owned
    wr(2, 8'h02);
    chk("R4 owner kept", active_loc, 8'd1);
    chk("R4 no pulse", {7'd0, loc_changed}, 8'h00);
    rd(2, 0, rv); chk("R4 requester read", rv, 8'h82);
    rd(1, 0, rv); chk("R4 owner pending", rv, 8'hA4);
    rd(0, 0, rv); chk("R4 other pending", rv, 8'h84);
    // R6 non-owner release clears its request
    wr(2, 8'h20);
    rd(2, 0, rv); chk("R6 request cleared", rv, 8'h80);
    chk("R6 owner kept", active_loc, 8'd1);
    // R11 masking: owner writes seize+release -> only seize (rejected)
    wr(1, 8'h28);
    chk("R11 release masked", active_loc, 8'd1);
    // R9 hardware locality writes ignored
    wr(4, 8'h08); chk("R9 seize ignored", active_loc, 8'd1);
    wr(1, 8'h20); chk("R5 release idle", active_loc, 8'hFF);
    chk("R5 no pulse to none", {7'd0, loc_changed}, 8'h00);
    wr(4, 8'h02); chk("R9 request ignored", active_loc, 8'hFF);
    rd(4, 0, rv); chk("R9 no flag", rv, 8'h80);
    // R11 seize+request from non-owner: seize acted on
    wr(0, 8'h02);
    wr(2, 8'h0A);
    chk("R11 seize taken", active_loc, 8'd2);
    rd(2, 0, rv); chk("R11 no request left", rv, 8'hA0);

    // R5 sweep: every owner, every request set
    for (int o = 0; o < 4; o++) begin
      for (int m = 0; m < 16; m++) begin
        int e;
        do_reset();
        wr(o, 8'h02);
        e = -1;
        for (int r = 0; r < 4; r++) begin
          if (m[r] && r != o) begin
            wr(r, 8'h02);
            e = r;
          end
        end
        wr(o, 8'h20);
        chk($sformatf("R5 o=%0d m=%0d", o, m), active_loc, (e < 0) ? 8'hFF : 8'(e));
        chk($sformatf("R5 pulse o=%0d m=%0d", o, m), {7'd0, loc_changed},
            (e < 0) ? 8'h00 : 8'h01);
      end
    end

    // R7 / R8 sweep: every owner and seizer
    for (int a = 0; a < 4; a++) begin
      for (int w = 0; w < 4; w++) begin
        do_reset();
        wr(a, 8'h02);
        wr(w, 8'h08);
        chk($sformatf("R7 a=%0d w=%0d", a, w), active_loc, (w > a) ? 8'(w) : 8'(a));
        if (w > a) begin
          rd(a, 0, rv); chk($sformatf("R8 seized a=%0d", a), rv, 8'h90);
          wr(a, 8'h10);
          rd(a, 0, rv); chk($sformatf("R8 cleared a=%0d", a), rv, 8'h80);
        end
      end
    end

    // R10 abort handshake
    do_reset();
    wr(1, 8'h02);
    cmd_busy = 1'b1;
    wr(3, 8'h08);
    chk("R10 abort raised", {7'd0, abort_req}, 8'h01);
    chk("R10 owner held", active_loc, 8'd1);
    wr(2, 8'h02);
    rd(2, 0, rv); chk("R10 write ignored", rv, 8'h80);
    chk("R10 still held", active_loc, 8'd1);
    abort_ack = 1'b1;
    @(negedge clk);
    abort_ack = 1'b0;
    chk("R10 switched", active_loc, 8'd3);
    chk("R10 abort dropped", {7'd0, abort_req}, 8'h00);
    chk("R10 pulse", {7'd0, loc_changed}, 8'h01);
    rd(1, 0, rv); chk("R8 busy seized", rv, 8'h90);
    wr(0, 8'h02);
    wr(3, 8'h20);
    chk("R10 release waits", active_loc, 8'd3);
    chk("R10 release abort", {7'd0, abort_req}, 8'h01);
    abort_ack = 1'b1;
    @(negedge clk);
    abort_ack = 1'b0;
    chk("R10 release done", active_loc, 8'd0);
    wr(0, 8'h20);
    chk("R10 idle release immediate", active_loc, 8'hFF);
    chk("R10 no abort to none", {7'd0, abort_req}, 8'h00);
    cmd_busy = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule